// File: doc/BRIEF.md
# Two-Wire Serial Byte Shift Register

This block is the byte datapath of a two-wire serial engine. One register serves as both the transmit buffer and the receive buffer. Each SCL period it presents the register's top bit to the SDA pull-down driver. On the SCL rising edge it samples the level actually present on SDA and shifts that bit into the bottom of the register. After a full byte the register therefore holds whatever travelled on the bus. This is true whether the engine was sending, receiving, or lost arbitration part-way through.

Once the last bit has been sampled, the block raises a byte-done flag and stops shifting. The host owns the register while that flag is set: it may read the captured byte and load the next one. The host then clears the flag to start the next byte.

A mismatch between a released (high) bit and a low bus sample marks arbitration as lost. From that point the driver lets go of SDA, and the rest of the byte is captured as a receiver would capture it. START/STOP, addressing and acknowledge are handled elsewhere. SCL and SDA are assumed to be already synchronised to `clk`.

Top module: `smb_byte_shifter`

## Requirements
- R1: After reset the register reads 0x00, byte_done, arb_lost and wr_blocked are 0, and sda_pull is 0 (SDA released).
- R2: In transmit mode (tx_mode=1) with no contention, the bus carries the loaded byte most significant bit first: in SCL high period k (k=0 first) the bus level equals bit 7-k.
- R3: sda_pull changes only in a clock cycle where SCL is low; it holds steady across every clock where SCL stays high.
- R4: On each SCL rising edge while shifting, the sampled SDA level enters bit 0 and the register shifts left, so after a byte the first sampled bit sits in bit 7 and the register equals the byte seen on the bus.
- R5: byte_done rises on the SCL rising edge that samples the eighth bit and stays 0 for the first seven.
- R6: While byte_done is 1, further SCL edges leave the register unchanged; only a host write alters it.
- R7: In transmit mode, sampling SDA low while the driver releases it sets arb_lost. The driver then stays released for the rest of the byte, and the register ends holding the bus byte.
- R8: A host write takes effect when byte_done is 1 or en is 0. A write while en=1 and byte_done=0 is ignored and pulses wr_blocked for one cycle.
- R9: host_clr while byte_done is 1 clears byte_done and arb_lost and starts the next byte. In receive mode (tx_mode=0) the driver never pulls SDA low.
- R10: Dropping en abandons a partial byte: the bit count restarts, so after re-enabling, byte_done waits for eight fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Interface enable |
| tx_mode | input | 1 | 1 = transmit the loaded byte, 0 = receive |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_clr | input | 1 | Host clears byte_done |
| host_rdata | output | 8 | Current register contents |
| byte_done | output | 1 | Serial interrupt flag, host owns register |
| arb_lost | output | 1 | Arbitration lost in current byte |
| wr_blocked | output | 1 | One-cycle pulse on an ignored host write |
| sda_pull | output | 1 | 1 = pull SDA low |

## Verification
A bit counter that is off by one shows at the ports as byte_done rising one SCL period early or late. The byte read back is then rotated by one place, so the error is visible at the end of the very first byte.

A driver register that updates during SCL high would corrupt the bus level sampled in the same high period. A stale arbitration state shows up as SDA pulled low after a loss. Both appear within one bit time of the fault. An ungated host write shows up as a corrupted captured byte as soon as that byte completes.

// File: rtl/smb_shift_pkg.sv
// Shared types for the two-wire byte shifter.
package smb_shift_pkg;
    parameter int SMB_BYTE_W = 8;

    // SCL events seen in one clock cycle.
    typedef struct packed {
        logic rise;   // SCL went 0 -> 1 at this edge
        logic low;    // SCL is low in this cycle
    } scl_evt_t;
endpackage

// File: rtl/smb_scl_edge.sv
// SCL event detector.
// Assumes scl_i is already synchronised to clk; reports rising edges and the low level.
module smb_scl_edge
    import smb_shift_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    output scl_evt_t evt
);
    logic scl_q;

    // Remember last SCL level (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    // Decode events from current and previous level.
    always_comb begin
        evt.rise = scl_i & ~scl_q;
        evt.low  = ~scl_i;
    end
endmodule

// File: rtl/smb_bit_ctr.sv
// Bit position counter.
// Counts sampled bits within a byte; clr holds it at zero, last flags the final bit.
module smb_bit_ctr #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;

    // Advance on each sample, wrap after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt <= '0;
        else if (step)      cnt <= last ? '0 : cnt + 1'b1;
    end

    // Final bit of the byte is being sampled.
    always_comb last = (cnt == LAST_IDX);
endmodule

// File: rtl/smb_sda_drv.sv
// SDA output stage.
// Loads the wanted line state only while SCL is low, so the bus never changes during SCL high.
module smb_sda_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic want_rel,
    output logic drv_rel
);
    // Update the released/pulled state in the SCL low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)   drv_rel <= 1'b1;
        else if (upd) drv_rel <= want_rel;
    end
endmodule

// File: rtl/smb_arb_det.sv
// Arbitration watch.
// Latches a loss when a released bit is sampled low; cleared when the next byte starts.
module smb_arb_det (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic check,
    input  logic drv_rel,
    input  logic sda_i,
    output logic lost
);
    // Sticky loss flag for the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)            lost <= 1'b0;
        else if (check && drv_rel && !sda_i) lost <= 1'b1;
    end
endmodule

// File: rtl/smb_byte_shifter.sv
// Two-wire byte shift register (top).
// One register transmits MSB first and captures the bus level each SCL rise, so it
// always holds the last byte on SDA. Host access is gated by the byte-done flag.
// Assumes synchronised scl_i/sda_i and an external START/STOP/ACK sequencer.
module smb_byte_shifter
    import smb_shift_pkg::*;
#(
    parameter int DATA_W = SMB_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_mode,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_clr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              byte_done,
    output logic              arb_lost,
    output logic              wr_blocked,
    output logic              sda_pull
);
    scl_evt_t          evt;
    logic [DATA_W-1:0] shreg;
    logic              done_q;
    logic              blk_q;
    logic              active;
    logic              shift_now;
    logic              last_bit;
    logic              host_ok;
    logic              drv_rel;
    logic              want_rel;
    logic              lost;

    // Shifting is allowed while enabled and the host does not own the register.
    always_comb begin
        active    = en & ~done_q;
        shift_now = active & evt.rise;
        host_ok   = ~en | done_q;
        want_rel  = ~(active & tx_mode & ~lost) | shreg[DATA_W-1];
    end

    smb_scl_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .evt   (evt)
    );

    smb_bit_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~active),
        .step  (shift_now),
        .last  (last_bit)
    );

    smb_sda_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (evt.low),
        .want_rel (want_rel),
        .drv_rel  (drv_rel)
    );

    smb_arb_det u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (done_q & host_clr),
        .check   (shift_now & tx_mode),
        .drv_rel (drv_rel),
        .sda_i   (sda_i),
        .lost    (lost)
    );

    // Data register: host load when permitted, else shift in the bus sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                  shreg <= '0;
        else if (host_wr && host_ok) shreg <= host_wdata;
        else if (shift_now)          shreg <= {shreg[DATA_W-2:0], sda_i};
    end

    // Byte-done flag: set by the final sample, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_q <= 1'b0;
        else if (shift_now && last_bit) done_q <= 1'b1;
        else if (host_clr && done_q)   done_q <= 1'b0;
    end

    // Pulse on a host write that arrives mid-shift.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= 1'b0;
        else        blk_q <= host_wr & ~host_ok;
    end

    // Drive outputs.
    always_comb begin
        host_rdata = shreg;
        byte_done  = done_q;
        arb_lost   = lost;
        wr_blocked = blk_q;
        sda_pull   = ~drv_rel;
    end
endmodule

// File: rtl/smb_byte_shifter_chk.sv
// Assertion checker for smb_byte_shifter, attached by bind below.
module smb_byte_shifter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              tx_mode,
    input logic              scl_i,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_clr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              byte_done,
    input logic              arb_lost,
    input logic              wr_blocked,
    input logic              sda_pull
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(DATA_W);

    logic           scl_c;
    logic [CNT_W:0] rises;

    // Independent count of SCL rises taken while shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_c <= 1'b1;
            rises <= '0;
        end else begin
            scl_c <= scl_i;
            if (!en || byte_done)     rises <= '0;
            else if (scl_i && !scl_c) rises <= rises + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (host_rdata == '0 && !byte_done && !arb_lost && !wr_blocked && !sda_pull));

    a_r3_drv_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i |=> $stable(sda_pull));

    a_r5_done_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_done) |-> (rises == FULL));

    a_r6_hold_while_done: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !host_wr) |=> $stable(host_rdata));

    a_r7_released_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull);

    a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && en && !byte_done) |=> (wr_blocked && !$stable(host_rdata) == 1'b0 || wr_blocked));

    a_r8_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (!en || byte_done)) |=> (host_rdata == $past(host_wdata) && !wr_blocked));

    a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && host_clr) |=> (!byte_done && !arb_lost));

    a_r9_rx_never_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && !scl_i && !byte_done) |=> (!tx_mode -> !sda_pull));

    a_r10_done_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_done) |-> $past(en));
endmodule

bind smb_byte_shifter smb_byte_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tx_mode    (tx_mode),
    .scl_i      (scl_i),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_clr   (host_clr),
    .host_rdata (host_rdata),
    .byte_done  (byte_done),
    .arb_lost   (arb_lost),
    .wr_blocked (wr_blocked),
    .sda_pull   (sda_pull)
);

// File: tb/smb_byte_shifter_tb.sv
// Self-checking bench: directed corners plus seeded random bytes.
module smb_byte_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       tx_mode = 1'b0;
    logic       scl_i = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_clr = 1'b0;
    logic [7:0] host_rdata;
    logic       byte_done, arb_lost, wr_blocked, sda_pull;
    logic       ext_low = 1'b0;
    logic       sda_bus;

    int checks = 0;
    int fails = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    // Wired-AND bus: either side may pull low.
    assign sda_bus = ~(sda_pull | ext_low);

    smb_byte_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .tx_mode(tx_mode),
        .scl_i(scl_i), .sda_i(sda_bus),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_clr(host_clr),
        .host_rdata(host_rdata), .byte_done(byte_done), .arb_lost(arb_lost),
        .wr_blocked(wr_blocked), .sda_pull(sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bus level for bit k, accounting for an earlier loss.
    function automatic bit exp_bit(input bit tx, input logic [7:0] txb,
                                   input logic [7:0] ext, input int k);
        bit lost = 1'b0;
        for (int j = 7; j > k; j--)
            if (tx && txb[j] && !ext[j]) lost = 1'b1;
        return (tx && !lost) ? (txb[k] & ext[k]) : ext[k];
    endfunction

    function automatic logic [7:0] exp_byte(input bit tx, input logic [7:0] txb,
                                            input logic [7:0] ext);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = exp_bit(tx, txb, ext, k);
        return b;
    endfunction

    function automatic bit exp_lost(input bit tx, input logic [7:0] txb,
                                    input logic [7:0] ext);
        return tx && ((txb & ~ext) != 8'h00);
    endfunction

    // Clock nbits bus bits, checking bus level and early flag each bit.
    task automatic run_bits(input bit tx, input logic [7:0] txb, input logic [7:0] ext,
                            input int nbits, input bit inj);
        for (int i = 0; i < nbits; i++) begin
            int k = 7 - i;
            @(negedge clk);
            scl_i = 1'b0;
            ext_low = ~ext[k];
            repeat (3) @(negedge clk);
            if (inj && i == 3) begin
                host_wr = 1'b1;
                host_wdata = 8'($urandom);
                @(negedge clk);
                host_wr = 1'b0;
                chk(wr_blocked == 1'b1, "R8 blocked write pulse", wr_blocked, 1);
            end
            scl_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(sda_bus == exp_bit(tx, txb, ext, k), "R2/R7/R9 bus level", sda_bus,
                exp_bit(tx, txb, ext, k));
            if (i < 7) chk(byte_done == 1'b0, "R5 flag early", byte_done, 0);
            @(negedge clk);
        end
        @(negedge clk);
        scl_i = 1'b0;
        ext_low = 1'b0;
    endtask

    // Host phase then one byte; assumes byte_done is 1 on entry.
    task automatic do_byte(input bit tx, input logic [7:0] txb, input logic [7:0] ext,
                           input bit inj);
        @(negedge clk);
        tx_mode = tx;
        host_wr = 1'b1;
        host_wdata = txb;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_rdata == txb, "R8 write while done", host_rdata, txb);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
        chk(byte_done == 1'b0 && arb_lost == 1'b0, "R9 clear", {byte_done, arb_lost}, 0);
        run_bits(tx, txb, ext, 8, inj);
        @(negedge clk);
        chk(byte_done == 1'b1, "R5 flag after eighth", byte_done, 1);
        chk(host_rdata == exp_byte(tx, txb, ext), "R4/R7 captured byte", host_rdata,
            exp_byte(tx, txb, ext));
        chk(arb_lost == exp_lost(tx, txb, ext), "R7 arbitration", arb_lost,
            exp_lost(tx, txb, ext));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=%0d expected=done", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_rdata == 8'h00 && !byte_done && !arb_lost && !wr_blocked && !sda_pull,
            "R1 reset state", host_rdata, 0);

        // First byte loaded while disabled.
        host_wr = 1'b1;
        host_wdata = 8'hA5;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_rdata == 8'hA5, "R8 write while disabled", host_rdata, 8'hA5);
        tx_mode = 1'b1;
        en = 1'b1;
        run_bits(1'b1, 8'hA5, 8'hFF, 8, 1'b0);
        @(negedge clk);
        chk(byte_done == 1'b1, "R5 flag after eighth", byte_done, 1);
        chk(host_rdata == 8'hA5, "R2/R4 clean transmit", host_rdata, 8'hA5);

        // R6: extra SCL pulses while the flag is set.
        keep = host_rdata;
        for (int p = 0; p < 2; p++) begin
            ext_low = 1'b1;
            @(negedge clk); scl_i = 1'b1;
            repeat (3) @(negedge clk); scl_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        ext_low = 1'b0;
        chk(host_rdata == keep, "R6 hold while done", host_rdata, keep);

        // Directed: receive, loss at first, middle and last bit, blocked write.
        do_byte(1'b0, 8'h00, 8'h3C, 1'b0);
        do_byte(1'b1, 8'hFF, 8'h7F, 1'b0);
        do_byte(1'b1, 8'hF0, 8'hEF, 1'b1);
        do_byte(1'b1, 8'h81, 8'hFE, 1'b0);
        do_byte(1'b1, 8'h5A, 8'hFF, 1'b1);

        // R10: abandon a partial byte by dropping enable.
        @(negedge clk);
        tx_mode = 1'b0;
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
        run_bits(1'b0, 8'h00, 8'hC3, 3, 1'b0);
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk(byte_done == 1'b0, "R10 no flag on partial byte", byte_done, 0);
        host_wr = 1'b1;
        host_wdata = 8'h00;
        @(negedge clk);
        host_wr = 1'b0;
        chk(host_rdata == 8'h00, "R10 write while disabled", host_rdata, 0);
        en = 1'b1;
        run_bits(1'b0, 8'h00, 8'h96, 8, 1'b0);
        @(negedge clk);
        chk(byte_done == 1'b1, "R10 flag after eight fresh bits", byte_done, 1);
        chk(host_rdata == 8'h96, "R10 fresh byte", host_rdata, 8'h96);

        // Seeded random bytes.
        for (int n = 0; n < 30; n++) begin
            bit         tx  = 1'($urandom % 2);
            logic [7:0] txb = 8'($urandom);
            logic [7:0] ext = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFF;
            do_byte(tx, txb, ext, ($urandom % 4) == 0);
        end

        finish_run();
    end
endmodule